// File: doc/BRIEF.md
# Write Burst Strobe and Data Formatter

This block sits between a memory controller's multi-phase write interface and the serializers of a DRAM data byte group. Each system clock it sees eight phases of 32-bit write data plus a per-phase write-enable. A write-enable on any phase arms one burst. The data presented in the system cycle right after the arming cycle is reshuffled into a 16-beat serial burst for each of 16 data lines. Write data in every other cycle is discarded.

Alongside the data the block builds the strobe waveform for two strobe lanes, the slot-by-slot output-enable and the data-mask lanes. The strobe has a fixed preamble in the second half of the cycle before the burst and a fixed postamble in the first half of the cycle after it. Every output is a parallel slot vector per system clock, with slot 0 first in time, ready for an external serializer. The data vectors and the strobe vectors are kept separate so that each can be serialized on its own phase-shifted fast clock. The data lanes run a quarter fast-clock period behind the strobe lanes.

The input is a plain phase interface without back-pressure. The controller owns the write timing, so the block can never stall the controller. A burst can be armed in any cycle, including back to back.

Top module: `wrburst_fmt`

## Requirements
- R1: While reset is held, and in the first cycle after it, every bit of `dq_slots`, `dqs_slots`, `dmi_slots` and `oe_slots` is 0.
- R2: In the burst cycle, data pin i slot 2p carries bit i of phase p and slot 2p+1 carries bit i+16 of phase p. Phase p occupies `wr_data_ph[32p+31:32p]` and pin i occupies `dq_slots[16i+15:16i]`.
- R3: Only the data presented in the cycle right after an arming cycle reaches `dq_slots`, one cycle later. Outside burst cycles `dq_slots` is all zero, whatever is on `wr_data_ph`.
- R4: A write-enable on any single phase, or on several phases, arms exactly one burst.
- R5: In the burst cycle every strobe lane reads 0,1 repeated over all 16 slots (lane value 16'hAAAA, slot 0 at the LSB).
- R6: In the cycle before the burst, slots 0..7 of each strobe lane are 0 and slots 8..15 are 0,0,0,0,0,1,0,1 (lane value 16'hA000).
- R7: In the cycle after the burst, slots 0..7 of each strobe lane are 0,0,0,1,0,1,0,1 and slots 8..15 are 0 (lane value 16'h00A8).
- R8: Both data-mask lanes are 0 in every slot at all times.
- R9: `oe_slots` is 16'hFF00 in the preamble cycle, 16'hFFFF in the burst cycle and 16'h00FF in the postamble cycle. It is 0 in all other cycles.
- R10: When windows of two bursts meet in one cycle, the burst pattern takes priority over a preamble or postamble. A postamble and a preamble in the same cycle merge by halves, giving strobe lane 16'hA0A8 and `oe_slots` 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_ph | input | 8 | Per-phase write-enable; any bit arms a burst |
| wr_data_ph | input | 256 | Write data, 32 bits per phase, phase 0 in the low bits |
| dq_slots | output | 256 | 16 slots per data pin, pin 0 in the low bits |
| dqs_slots | output | 32 | 16 slots per strobe lane |
| dmi_slots | output | 32 | 16 slots per data-mask lane, always 0 |
| oe_slots | output | 16 | Per-slot output-enable for the byte group |

## Verification
Two window functions can land in the same system cycle. The first case is a burst pattern with the preamble or postamble of a neighbouring burst, provoked by arming in two consecutive cycles. The second case is one burst's postamble with the next burst's preamble, provoked by arming with one idle cycle between. In the consecutive case, both bursts must carry their own data and the strobe must stay 16'hAAAA with no preamble or postamble bits mixed in. In the gapped case, the shared cycle must show 16'hA0A8 with full output-enable and no data, even though junk data is driven on the bus during that cycle.

// File: rtl/wbf_pkg.sv
package wbf_pkg;

  // One-hot window state: which part of a burst the current output cycle holds.
  typedef struct packed {
    logic post;
    logic burst;
    logic pre;
  } wbf_win_t;

  // Steady toggle 0,1,0,1... with slot 0 at the LSB.
  function automatic logic [63:0] toggle_pat(input int n);
    logic [63:0] v;
    v = '0;
    for (int j = 0; j < n; j++) v[j] = j[0];
    return v;
  endfunction

  // Lead-in half window: quiet, then the last two odd slots high.
  function automatic logic [63:0] lead_half(input int half);
    logic [63:0] v;
    v = '0;
    for (int j = 0; j < half; j++) v[j] = j[0] && (j >= half - 3);
    return v;
  endfunction

  // Trail-out half window: three odd slots high from the fourth slot.
  function automatic logic [63:0] trail_half(input int half);
    logic [63:0] v;
    v = '0;
    for (int j = 0; j < half; j++) v[j] = j[0] && (j >= half - 5);
    return v;
  endfunction

endpackage

// File: rtl/wbf_window.sv
module wbf_window
  import wbf_pkg::*;
#(
  parameter int NPHASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPHASE-1:0] en_ph,
  output wbf_win_t          win
);

  // Arming cycle N -> preamble output after edge N, burst after N+1, postamble after N+2.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= '0;
    end else begin
      win.pre   <= |en_ph;
      win.burst <= win.pre;
      win.post  <= win.burst;
    end
  end

endmodule

// File: rtl/wbf_dq_shuffle.sv
module wbf_dq_shuffle #(
  parameter int NPHASE = 8,
  parameter int DQ_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic [NPHASE*2*DQ_W-1:0] data_ph,
  output logic [DQ_W*2*NPHASE-1:0] dq_slots
);

  localparam int PW    = 2 * DQ_W;
  localparam int BEATS = 2 * NPHASE;

  logic [DQ_W*BEATS-1:0] shuffled;

  for (genvar i = 0; i < DQ_W; i++) begin : g_pin
    for (genvar p = 0; p < NPHASE; p++) begin : g_phase
      assign shuffled[i*BEATS + 2*p]     = data_ph[p*PW + i];
      assign shuffled[i*BEATS + 2*p + 1] = data_ph[p*PW + DQ_W + i];
    end
  end

  // Data is loaded only in the cycle following an arm; otherwise the lines idle low.
  always_ff @(posedge clk) begin
    if (!rst_n)    dq_slots <= '0;
    else if (take) dq_slots <= shuffled;
    else           dq_slots <= '0;
  end

endmodule

// File: rtl/wbf_strobe.sv
module wbf_strobe
  import wbf_pkg::*;
#(
  parameter int NPHASE = 8,
  parameter int NSTB   = 2
) (
  input  wbf_win_t                 win,
  output logic [NSTB*2*NPHASE-1:0] dqs_slots,
  output logic [2*NPHASE-1:0]      oe_slots
);

  localparam int BEATS = 2 * NPHASE;
  localparam int HALF  = NPHASE;

  localparam logic [63:0] TOG64  = toggle_pat(BEATS);
  localparam logic [63:0] LEAD64 = lead_half(HALF) << HALF;
  localparam logic [63:0] TRL64  = trail_half(HALF);
  localparam logic [63:0] ONES64 = '1;

  localparam logic [BEATS-1:0] BURST_PAT = TOG64[BEATS-1:0];
  localparam logic [BEATS-1:0] LEAD_PAT  = LEAD64[BEATS-1:0];
  localparam logic [BEATS-1:0] TRAIL_PAT = TRL64[BEATS-1:0];
  localparam logic [BEATS-1:0] HI_HALF   = ONES64[BEATS-1:0] << HALF;
  localparam logic [BEATS-1:0] LO_HALF   = ~HI_HALF;

  logic [BEATS-1:0] lane;

  always_comb begin
    lane     = '0;
    oe_slots = '0;
    if (win.pre) begin
      lane     = lane | LEAD_PAT;
      oe_slots = oe_slots | HI_HALF;
    end
    if (win.post) begin
      lane     = lane | TRAIL_PAT;
      oe_slots = oe_slots | LO_HALF;
    end
    if (win.burst) begin
      lane     = BURST_PAT;
      oe_slots = '1;
    end
  end

  for (genvar s = 0; s < NSTB; s++) begin : g_lane
    assign dqs_slots[s*BEATS +: BEATS] = lane;
  end

endmodule

// File: rtl/wrburst_fmt.sv
module wrburst_fmt
  import wbf_pkg::*;
#(
  parameter int NPHASE = 8,
  parameter int DQ_W   = 16,
  parameter int NSTB   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPHASE-1:0]        wr_en_ph,
  input  logic [NPHASE*2*DQ_W-1:0] wr_data_ph,
  output logic [DQ_W*2*NPHASE-1:0] dq_slots,
  output logic [NSTB*2*NPHASE-1:0] dqs_slots,
  output logic [NSTB*2*NPHASE-1:0] dmi_slots,
  output logic [2*NPHASE-1:0]      oe_slots
);

  wbf_win_t win;

  wbf_window #(.NPHASE(NPHASE)) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .en_ph (wr_en_ph),
    .win   (win)
  );

  wbf_dq_shuffle #(.NPHASE(NPHASE), .DQ_W(DQ_W)) u_shuffle (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (win.pre),
    .data_ph  (wr_data_ph),
    .dq_slots (dq_slots)
  );

  wbf_strobe #(.NPHASE(NPHASE), .NSTB(NSTB)) u_strobe (
    .win       (win),
    .dqs_slots (dqs_slots),
    .oe_slots  (oe_slots)
  );

  // Masking is not supported; mask lanes stay low.
  assign dmi_slots = '0;

endmodule

// File: rtl/wrburst_fmt_chk.sv
module wrburst_fmt_chk
  import wbf_pkg::*;
#(
  parameter int NPHASE = 8,
  parameter int DQ_W   = 16,
  parameter int NSTB   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPHASE-1:0]        wr_en_ph,
  input logic [DQ_W*2*NPHASE-1:0] dq_slots,
  input logic [NSTB*2*NPHASE-1:0] dqs_slots,
  input logic [NSTB*2*NPHASE-1:0] dmi_slots,
  input logic [2*NPHASE-1:0]      oe_slots
);

  localparam int BEATS = 2 * NPHASE;
  localparam int HALF  = NPHASE;
  localparam logic [63:0] TOG64 = toggle_pat(BEATS);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_MASK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dmi_slots == '0);  // R8

  AST_LEAD_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en_ph) |=> (&oe_slots[BEATS-1:HALF]));  // R9

  AST_BURST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && (|$past(wr_en_ph, 2))) |-> (dqs_slots[BEATS-1:0] == TOG64[BEATS-1:0]));  // R5

  AST_TRAIL_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && (|$past(wr_en_ph, 3))) |-> (&oe_slots[HALF-1:0]));  // R9

  AST_DQ_ONLY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_slots != '0) |-> (age >= 2'd2 && (|$past(wr_en_ph, 2))));  // R3

  AST_STROBE_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_slots != '0) |-> (oe_slots != '0));  // R9

endmodule

bind wrburst_fmt wrburst_fmt_chk #(.NPHASE(NPHASE), .DQ_W(DQ_W), .NSTB(NSTB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en_ph  (wr_en_ph),
  .dq_slots  (dq_slots),
  .dqs_slots (dqs_slots),
  .dmi_slots (dmi_slots),
  .oe_slots  (oe_slots)
);

// File: tb/wrburst_fmt_bench.sv
module wrburst_fmt_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NPHASE = 8;
  localparam int DQ_W   = 16;
  localparam int NSTB   = 2;
  localparam int BEATS  = 16;
  localparam int DW     = 256;

  localparam logic [15:0] S_BURST = 16'hAAAA;
  localparam logic [15:0] S_LEAD  = 16'hA000;
  localparam logic [15:0] S_TRAIL = 16'h00A8;
  localparam logic [15:0] S_MERGE = 16'hA0A8;

  // {enable mask, data seed, expected oe in the lead cycle}
  localparam logic [55:0] VEC [6] = '{
    {8'h01, 32'h1234_5678, 16'hFF00},
    {8'h80, 32'hDEAD_BEEF, 16'hFF00},
    {8'h08, 32'h0F0F_00FF, 16'hFF00},
    {8'hFF, 32'hFFFE_FFFF, 16'hFF00},
    {8'h24, 32'h8000_0001, 16'hFF00},
    {8'h40, 32'h5A5A_C3C3, 16'hFF00}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NPHASE-1:0]   wr_en_ph = '0;
  logic [DW-1:0]       wr_data_ph = '0;
  logic [DW-1:0]       dq_slots;
  logic [31:0]         dqs_slots;
  logic [31:0]         dmi_slots;
  logic [15:0]         oe_slots;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrburst_fmt #(.NPHASE(NPHASE), .DQ_W(DQ_W), .NSTB(NSTB)) u_wrburst_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_ph   (wr_en_ph),
    .wr_data_ph (wr_data_ph),
    .dq_slots   (dq_slots),
    .dqs_slots  (dqs_slots),
    .dmi_slots  (dmi_slots),
    .oe_slots   (oe_slots)
  );

  function automatic logic [DW-1:0] make_data(input logic [31:0] seed);
    logic [DW-1:0] d;
    for (int p = 0; p < NPHASE; p++)
      d[p*32 +: 32] = {seed[31-p*3 -: 8], seed[23:0]} ^ (32'h0101_0101 * p);
    return d;
  endfunction

  // Expected burst per R2: pin i slot 2p = bit i of phase p, slot 2p+1 = bit i+16.
  function automatic logic [DW-1:0] expect_dq(input logic [DW-1:0] d);
    logic [DW-1:0] e;
    for (int i = 0; i < DQ_W; i++)
      for (int p = 0; p < NPHASE; p++) begin
        e[i*BEATS + 2*p]     = d[p*32 + i];
        e[i*BEATS + 2*p + 1] = d[p*32 + 16 + i];
      end
    return e;
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic check_win(input logic [15:0] lane, input logic [15:0] oe,
                           input logic [DW-1:0] dq, input string what);
    check(DW'(dqs_slots), DW'({lane, lane}), {what, " strobe"});
    check(DW'(oe_slots), DW'(oe), {what, " oe"});
    check(dq_slots, dq, {what, " dq"});
    check(DW'(dmi_slots), '0, "R8 mask lanes low");
  endtask

  task automatic step(input logic [NPHASE-1:0] en, input logic [DW-1:0] d);
    wr_en_ph   = en;
    wr_data_ph = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d1;
    logic [DW-1:0] d2;
    logic [DW-1:0] junk;
    junk = make_data(32'hC0FF_EE11);

    // R1: reset state
    repeat (3) @(negedge clk);
    check_win(16'h0, 16'h0, '0, "R1 during reset");
    rst_n = 1'b1;
    step('0, junk);
    check_win(16'h0, 16'h0, '0, "R1 after reset");

    // Table walk: R2 R4 R5 R6 R7 R9
    for (int k = 0; k < 6; k++) begin
      d1 = make_data(VEC[k][47:16]);
      step(VEC[k][55:48], junk);
      check_win(S_LEAD, VEC[k][15:0], '0, "R6 lead cycle");
      step('0, d1);
      check_win(S_BURST, 16'hFFFF, expect_dq(d1), "R2 R4 R5 burst cycle");
      step('0, junk);
      check_win(S_TRAIL, 16'h00FF, '0, "R7 trail cycle");
      step('0, junk);
      check_win(16'h0, 16'h0, '0, "R9 idle after burst");
    end

    // R3: data without any arm never reaches the pins
    for (int k = 0; k < 3; k++) begin
      step('0, make_data(32'h7777_0000 + k));
      check_win(16'h0, 16'h0, '0, "R3 unarmed data ignored");
    end

    // R10: back-to-back arms
    d1 = make_data(32'hAAAA_0001);
    d2 = make_data(32'h5555_0002);
    step(8'h02, junk);
    check_win(S_LEAD, 16'hFF00, '0, "R10 b2b lead");
    step(8'h10, d1);
    check_win(S_BURST, 16'hFFFF, expect_dq(d1), "R10 b2b first burst");
    step('0, d2);
    check_win(S_BURST, 16'hFFFF, expect_dq(d2), "R10 b2b second burst");
    step('0, junk);
    check_win(S_TRAIL, 16'h00FF, '0, "R10 b2b trail");
    step('0, junk);
    check_win(16'h0, 16'h0, '0, "R10 b2b idle");

    // R10: one idle cycle between arms -> trail and lead share a cycle
    step(8'h01, junk);
    check_win(S_LEAD, 16'hFF00, '0, "R10 gap lead");
    step('0, d1);
    check_win(S_BURST, 16'hFFFF, expect_dq(d1), "R10 gap first burst");
    step(8'h80, junk);
    check_win(S_MERGE, 16'hFFFF, '0, "R10 R3 merged trail+lead");
    step('0, d2);
    check_win(S_BURST, 16'hFFFF, expect_dq(d2), "R10 gap second burst");
    step('0, junk);
    check_win(S_TRAIL, 16'h00FF, '0, "R10 gap trail");
    step('0, '0);
    check_win(16'h0, 16'h0, '0, "R10 gap idle");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule